// File: doc/BRIEF.md
# Operand Store Packer

This block takes an operand held in unpacked form (a sign, an 18-bit signed exponent and a 35-bit magnitude fraction split into a 17-bit upper part and an 18-bit lower part) and turns it into the sequence of 18-bit memory words for one of four storage formats. The formats are single integer, double integer, single float and double float. Mode inputs choose integer or float, single or double width, and whether rounding is suppressed.

A one-cycle start pulse captures the operand and the mode. The block then emits one word per cycle with a valid strobe and a word index. In the same cycle as the last word it raises a done strobe that carries a status code. For a single float it first rounds at the narrow fraction boundary, which may re-normalize the fraction, and then checks the exponent against the 9-bit field. For integers it checks the range and converts the magnitude back to two's complement. An out-of-range operand produces no words. Its done strobe then appears in the first busy cycle with a nonzero status. Each store also pulses a strobe that tells the surrounding datapath to clear its guard flag.

Top module: `fpk_store_packer`

## Requirements
- R1: A start pulse while idle captures the operand and mode. Busy is high from the next cycle through the cycle that carries done, and low in the cycle after. A start pulse seen while busy is ignored and produces no extra output.
- R2: Word counts are 1 for single integer, 2 for double integer, 2 for single float and 3 for double float. The index output counts 0, 1, 2 across consecutive cycles, starting in the first busy cycle.
- R3: Single float (float=1, double=0) gives word 0 = {fraction-low bits 17:9, exponent bits 8:0} and word 1 = {sign, 17-bit upper fraction}.
- R4: For a single float with rounding enabled and fraction-low bit 8 set, 1 is added at bit 8, bits 8:0 are cleared, and any carry runs into the upper fraction.
- R5: If that rounding carries out of the full 35-bit fraction, the upper fraction becomes 0x10000, the lower fraction becomes 0, and the exponent is incremented before the range check.
- R6: With the no-round input set, a single float's fraction-low bits 8:0 are discarded with no increment.
- R7: A single float whose (rounded) exponent exceeds 255 reports overflow. One below -256 reports underflow. In both cases no word is emitted, and done appears in the first busy cycle.
- R8: Double float (float=1, double=1) gives the 18-bit exponent, then {sign, upper fraction}, then the lower fraction.
- R9: Single integer (float=0, double=0) reports overflow if the upper fraction is nonzero or lower bit 17 is set. Otherwise it emits the lower part, negated in 18-bit two's complement when the sign is 1.
- R10: Double integer (float=0, double=1) with sign 0 emits {0, upper} then lower. With sign 1 it emits the 35-bit two's complement of the magnitude, with bit 17 of word 0 forced to 1.
- R11: The status is 0 for ok, 1 for overflow and 3 for underflow. It is valid only while done is high and reads 0 at all other times.
- R12: The guard-clear strobe is high for exactly the first busy cycle of every store, including stores that fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, captures operand and mode |
| is_float_i | input | 1 | 1 = float format, 0 = integer |
| is_double_i | input | 1 | 1 = double width, 0 = single |
| no_round_i | input | 1 | 1 = suppress single-float rounding |
| sign_i | input | 1 | Operand sign |
| exp_i | input | 18 | Exponent, two's complement |
| frac_hi_i | input | 17 | Upper fraction magnitude |
| frac_lo_i | input | 18 | Lower fraction magnitude |
| busy_o | output | 1 | Store in progress |
| word_vld_o | output | 1 | Output word valid |
| word_o | output | 18 | Packed memory word |
| word_idx_o | output | 2 | Index of the word within the store |
| done_o | output | 1 | Final cycle of the store |
| status_o | output | 2 | Completion code, valid with done |
| guard_clr_o | output | 1 | Guard-flag clear strobe |

## Verification
The embedded properties assume that the mode and operand are meaningful only while the capture registers hold them, and that a start pulse is only honoured while idle. The rounding-carry property also assumes that the operand it inspects is the one captured at start. The stimulus holds start for exactly one cycle and then waits for busy to fall before the next store, except in one deliberate case that pulses start mid-store to show the pulse is ignored. The operands include exponents on both sides of each single-float limit, fractions that carry partly or fully out on rounding, and zero and negative integer magnitudes.

// File: rtl/fpk_pkg.sv
package fpk_pkg;
  typedef enum logic [1:0] {
    ST_OK  = 2'd0,
    ST_OVF = 2'd1,
    ST_UNF = 2'd3
  } fpk_status_e;

  typedef struct packed {
    logic is_float;
    logic is_double;
    logic no_round;
  } fpk_mode_t;
endpackage

// File: rtl/fpk_sfloat_round.sv
// Single-float rounding at the narrow fraction boundary plus exponent range check.
module fpk_sfloat_round #(
  parameter int HI_W  = 17,
  parameter int LO_W  = 18,
  parameter int EXP_W = 18,
  parameter int SE_W  = 9
) (
  input  logic [HI_W-1:0]  hi_i,
  input  logic [LO_W-1:0]  lo_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             no_round_i,
  output logic [HI_W-1:0]  hi_o,
  output logic [LO_W-1:0]  lo_o,
  output logic [SE_W-1:0]  exp_field_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam int FW = HI_W + LO_W;
  localparam logic [FW:0] RND_ADD = (FW+1)'(1) << (SE_W - 1);
  localparam logic [FW-1:0] KEEP_MASK = ~((FW)'(1) << SE_W) + (FW)'(1) & ~((FW)'((1 << SE_W) - 1));
  localparam logic signed [EXP_W:0] E_MAX = (EXP_W+1)'((1 << (SE_W - 1)) - 1);
  localparam logic signed [EXP_W:0] E_MIN = -(EXP_W+1)'(1 << (SE_W - 1));

  logic             rnd;
  logic [FW:0]      sum;
  logic [FW-1:0]    frac;
  logic [EXP_W:0]   exp_w;
  logic [EXP_W:0]   exp_r;

  always_comb begin
    rnd   = !no_round_i && lo_i[SE_W-1];
    sum   = {1'b0, hi_i, lo_i} + (rnd ? RND_ADD : '0);
    frac  = sum[FW-1:0] & ~((FW)'((1 << SE_W) - 1));
    exp_w = {exp_i[EXP_W-1], exp_i};
    if (rnd && (frac == '0)) begin
      hi_o  = (HI_W)'(1) << (HI_W - 1);
      lo_o  = '0;
      exp_r = exp_w + {{EXP_W{1'b0}}, 1'b1};
    end else begin
      hi_o  = frac[FW-1:LO_W];
      lo_o  = frac[LO_W-1:0];
      exp_r = exp_w;
    end
    exp_field_o = exp_r[SE_W-1:0];
    ovf_o = $signed(exp_r) > E_MAX;
    unf_o = $signed(exp_r) < E_MIN;
  end

  logic unused_mask;
  assign unused_mask = ^KEEP_MASK;
endmodule

// File: rtl/fpk_int_pack.sv
// Integer range check and magnitude-to-two's-complement conversion.
module fpk_int_pack #(
  parameter int HI_W = 17,
  parameter int LO_W = 18
) (
  input  logic            sign_i,
  input  logic            double_i,
  input  logic [HI_W-1:0] hi_i,
  input  logic [LO_W-1:0] lo_i,
  output logic [LO_W-1:0] w0_o,
  output logic [LO_W-1:0] w1_o,
  output logic            ovf_o
);
  localparam int FW = HI_W + LO_W;

  logic [FW-1:0] neg;

  always_comb begin
    neg = ~{hi_i, lo_i} + (FW)'(1);
    if (double_i) begin
      ovf_o = 1'b0;
      w0_o  = sign_i ? {1'b1, neg[FW-1:LO_W]} : {1'b0, hi_i};
      w1_o  = sign_i ? neg[LO_W-1:0] : lo_i;
    end else begin
      ovf_o = (|hi_i) | lo_i[LO_W-1];
      w0_o  = sign_i ? neg[LO_W-1:0] : lo_i;
      w1_o  = '0;
    end
  end
endmodule

// File: rtl/fpk_store_packer.sv
module fpk_store_packer
  import fpk_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int SE_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              is_float_i,
  input  logic              is_double_i,
  input  logic              no_round_i,
  input  logic              sign_i,
  input  logic [WORD_W-1:0] exp_i,
  input  logic [WORD_W-2:0] frac_hi_i,
  input  logic [WORD_W-1:0] frac_lo_i,
  output logic              busy_o,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o,
  output logic [1:0]        word_idx_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic              guard_clr_o
);
  localparam int HI_W  = WORD_W - 1;
  localparam int LO_W  = WORD_W;
  localparam int EXP_W = WORD_W;
  localparam int IDX_W = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // state and captured operand
  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  fpk_mode_t         mode_q;
  logic              sign_q;
  logic [EXP_W-1:0]  exp_q;
  logic [HI_W-1:0]   hi_q;
  logic [LO_W-1:0]   lo_q;
  logic              load_en;

  // datapath results
  logic [HI_W-1:0]   sf_hi;
  logic [LO_W-1:0]   sf_lo;
  logic [SE_W-1:0]   sf_exp;
  logic              sf_ovf, sf_unf;
  logic [LO_W-1:0]   int_w0, int_w1;
  logic              int_ovf;

  fpk_sfloat_round #(.HI_W(HI_W), .LO_W(LO_W), .EXP_W(EXP_W), .SE_W(SE_W)) u_round (
    .hi_i(hi_q), .lo_i(lo_q), .exp_i(exp_q), .no_round_i(mode_q.no_round),
    .hi_o(sf_hi), .lo_o(sf_lo), .exp_field_o(sf_exp), .ovf_o(sf_ovf), .unf_o(sf_unf)
  );

  fpk_int_pack #(.HI_W(HI_W), .LO_W(LO_W)) u_int (
    .sign_i(sign_q), .double_i(mode_q.is_double), .hi_i(hi_q), .lo_i(lo_q),
    .w0_o(int_w0), .w1_o(int_w1), .ovf_o(int_ovf)
  );

  // word selection, status and sequencing
  fpk_status_e       st;
  logic [IDX_W-1:0]  last_idx;
  logic [WORD_W-1:0] word_sel;
  logic              err, last, done;

  always_comb begin
    st       = ST_OK;
    last_idx = '0;
    word_sel = '0;
    unique case ({mode_q.is_float, mode_q.is_double})
      2'b00: begin
        last_idx = 2'd0;
        if (int_ovf) st = ST_OVF;
        word_sel = int_w0;
      end
      2'b01: begin
        last_idx = 2'd1;
        word_sel = (idx_q == 2'd0) ? int_w0 : int_w1;
      end
      2'b10: begin
        last_idx = 2'd1;
        if (sf_ovf)      st = ST_OVF;
        else if (sf_unf) st = ST_UNF;
        word_sel = (idx_q == 2'd0) ? {sf_lo[LO_W-1:SE_W], sf_exp} : {sign_q, sf_hi};
      end
      default: begin
        last_idx = 2'd2;
        case (idx_q)
          2'd0:    word_sel = exp_q;
          2'd1:    word_sel = {sign_q, hi_q};
          default: word_sel = lo_q;
        endcase
      end
    endcase
    err     = (st != ST_OK);
    last    = (idx_q == last_idx);
    done    = busy_q && (err || last);
    load_en = start_i && !busy_q;
    busy_d  = busy_q ? !done : start_i;
    idx_d   = (busy_q && !done) ? idx_q + 2'd1 : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      mode_q <= '0;
      sign_q <= 1'b0;
      exp_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      if (load_en) begin
        mode_q <= '{is_float: is_float_i, is_double: is_double_i, no_round: no_round_i};
        sign_q <= sign_i;
        exp_q  <= exp_i;
        hi_q   <= frac_hi_i;
        lo_q   <= frac_lo_i;
      end
    end
  end

  assign busy_o      = busy_q;
  assign word_vld_o  = busy_q && !err;
  assign word_o      = (busy_q && !err) ? word_sel : '0;
  assign word_idx_o  = idx_q;
  assign done_o      = done;
  assign status_o    = done ? st : ST_OK;
  assign guard_clr_o = busy_q && (idx_q == '0);

  // ---------------- assertions ----------------
  assert_vld_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    word_vld_o |-> busy_o);
  assert_done_ends_busy_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !busy_o);
  assert_first_idx_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy_o) |-> (word_idx_o == 2'd0));
  assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (word_vld_o && !done_o) |=> (word_vld_o && word_idx_o == 2'($past(word_idx_o) + 2'd1)));
  assert_sf_carry_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (word_vld_o && word_idx_o == 2'd1 && mode_q.is_float && !mode_q.is_double &&
     !mode_q.no_round && (&hi_q) && (&lo_q[LO_W-1:SE_W-1]))
    |-> (word_o == {sign_q, (HI_W)'(1) << (HI_W - 1)}));
  assert_err_no_words_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && status_o != 2'd0) |-> !word_vld_o);
  assert_sint_sign_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (word_vld_o && !mode_q.is_float && !mode_q.is_double && !sign_q) |-> !word_o[WORD_W-1]);
  assert_status_quiet_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done_o |-> (status_o == 2'd0));
  assert_guard_once_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    guard_clr_o |=> !guard_clr_o);
endmodule

// File: tb/fpk_store_packer_tb.sv
`timescale 1ns/1ps
module fpk_store_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, is_float_i, is_double_i, no_round_i, sign_i;
  logic [17:0] exp_i;
  logic [16:0] frac_hi_i;
  logic [17:0] frac_lo_i;
  logic        busy_o, word_vld_o, done_o, guard_clr_o;
  logic [17:0] word_o;
  logic [1:0]  word_idx_o, status_o;

  always #2.5 clk = ~clk;

  fpk_store_packer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_float_i(is_float_i),
    .is_double_i(is_double_i), .no_round_i(no_round_i), .sign_i(sign_i),
    .exp_i(exp_i), .frac_hi_i(frac_hi_i), .frac_lo_i(frac_lo_i),
    .busy_o(busy_o), .word_vld_o(word_vld_o), .word_o(word_o),
    .word_idx_o(word_idx_o), .done_o(done_o), .status_o(status_o),
    .guard_clr_o(guard_clr_o)
  );

  typedef struct {
    logic [24:0] pattern; // {vld, word, idx, done, status, guard_clr}
    string       req;
  } exp_item_t;

  exp_item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [24:0] act, input logic [24:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic void push(input logic vld, input logic [17:0] w, input logic [1:0] idx,
                               input logic dn, input logic [1:0] st, input logic first, input string req);
    exp_item_t it;
    it.pattern = {vld, w, idx, dn, st, first};
    it.req     = req;
    sb_q.push_back(it);
  endfunction

  // reference: expected words from the requirements
  function automatic void model(input bit fl, input bit db, input bit nr, input bit sg,
                                input logic [17:0] ex, input logic [16:0] hi,
                                input logic [17:0] lo, input string req);
    longint mag = (longint'(hi) << 18) | longint'(lo);
    longint m35 = (longint'(1) << 35) - 1;
    if (fl && !db) begin
      longint f = mag;
      int e = int'($signed(ex));
      bit rd = !nr && lo[8];
      if (rd) f = f + 256;
      f = f & m35 & ~longint'(511);
      if (rd && f == 0) begin
        f = longint'(17'h10000) << 18;
        e = e + 1;
      end
      if (e > 255)       push(0, 0, 0, 1, 2'd1, 1, req);
      else if (e < -256) push(0, 0, 0, 1, 2'd3, 1, req);
      else begin
        push(1, 18'((f & 18'h3FE00) | longint'(e & 9'h1FF)), 0, 0, 0, 1, req);
        push(1, {sg, 17'(f >> 18)}, 1, 1, 0, 0, req);
      end
    end else if (fl && db) begin
      push(1, ex, 0, 0, 0, 1, req);
      push(1, {sg, hi}, 1, 0, 0, 0, req);
      push(1, lo, 2, 1, 0, 0, req);
    end else if (!db) begin
      if (hi != 0 || lo[17]) push(0, 0, 0, 1, 2'd1, 1, req);
      else push(1, sg ? 18'((longint'(1) << 18) - longint'(lo)) : lo, 0, 1, 0, 1, req);
    end else begin
      longint ng = ((longint'(1) << 35) - mag) & m35;
      push(1, sg ? (18'h20000 | 18'(ng >> 18)) : {1'b0, hi}, 0, 0, 0, 1, req);
      push(1, sg ? 18'(ng) : lo, 1, 1, 0, 0, req);
    end
  endfunction

  task automatic store(input bit fl, input bit db, input bit nr, input bit sg,
                       input logic [17:0] ex, input logic [16:0] hi,
                       input logic [17:0] lo, input string req, input bit poke = 0);
    model(fl, db, nr, sg, ex, hi, lo, req);
    @(negedge clk);
    {is_float_i, is_double_i, no_round_i, sign_i} = {fl, db, nr, sg};
    exp_i = ex; frac_hi_i = hi; frac_lo_i = lo;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      // R1: pulse start mid-store with different data; must be ignored
      {is_float_i, is_double_i, sign_i} = 3'b001;
      frac_lo_i = 18'h00007; frac_hi_i = 0;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
  endtask

  // monitor: pops the scoreboard whenever the design produces a result
  always @(negedge clk) begin
    if (rst_n && !finished && (word_vld_o || done_o)) begin
      logic [24:0] act;
      act = {word_vld_o, word_o, word_idx_o, done_o, status_o, guard_clr_o};
      if (sb_q.size() == 0) check(0, "R1 unexpected output", act, '0);
      else begin
        exp_item_t it;
        it = sb_q.pop_front();
        check(act === it.pattern, it.req, act, it.pattern);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 0; is_float_i = 0; is_double_i = 0; no_round_i = 0; sign_i = 0;
    exp_i = 0; frac_hi_i = 0; frac_lo_i = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check({busy_o, word_vld_o, done_o, status_o, guard_clr_o} == 6'b0, "R1 reset",
          25'({busy_o, word_vld_o, done_o, status_o, guard_clr_o}), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    store(0, 0, 0, 0, 0, 17'h0,     18'h00005, "R9 single int positive");
    store(0, 0, 0, 1, 0, 17'h0,     18'h00005, "R9 single int negative");
    store(0, 0, 0, 0, 0, 17'h00001, 18'h00000, "R9 R11 single int ovf upper");
    store(0, 0, 0, 1, 0, 17'h0,     18'h20000, "R9 R12 single int ovf bit17");
    store(0, 1, 0, 0, 0, 17'h01234, 18'h02345, "R10 double int positive");
    store(0, 1, 0, 1, 0, 17'h0,     18'h00001, "R10 double int minus one");
    store(0, 1, 0, 1, 0, 17'h0,     18'h00000, "R10 double int negative zero");
    store(0, 1, 0, 1, 0, 17'h12345, 18'h3ABCD, "R10 double int negative");
    store(1, 0, 0, 0, 18'd5, 17'h10000, 18'h2A000, "R3 single float layout");
    store(1, 0, 0, 1, 18'h3FFF0, 17'h10000, 18'h00100, "R4 single float round");
    store(1, 0, 0, 0, 18'd7, 17'h10001, 18'h3FF00, "R4 round carry into upper");
    store(1, 0, 0, 0, 18'd3, 17'h1FFFF, 18'h3FF00, "R5 round full carry");
    store(1, 0, 1, 0, 18'd3, 17'h1FFFF, 18'h3FFFF, "R6 no round truncation");
    store(1, 0, 0, 0, 18'd255, 17'h10000, 0, "R7 exponent 255 ok");
    store(1, 0, 0, 0, 18'd256, 17'h10000, 0, "R7 R11 exponent 256 overflow");
    store(1, 0, 0, 0, 18'h3FF00, 17'h10000, 0, "R7 exponent -256 ok");
    store(1, 0, 0, 0, 18'h3FEFF, 17'h10000, 0, "R7 R11 exponent -257 underflow");
    store(1, 0, 0, 0, 18'd255, 17'h1FFFF, 18'h3FF00, "R5 R7 carry pushes exponent to overflow");
    store(1, 1, 0, 1, 18'h3FFF0, 17'h15555, 18'h2AAAA, "R8 double float");
    store(1, 1, 0, 0, 18'h00123, 17'h10000, 18'h00001, "R1 R2 double float with ignored start", 1);
    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R1 R2 scoreboard drained", 25'(sb_q.size()), '0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule